// File: doc/BRIEF.md
# Dual-Width Flash Read Port

This block models the read side of a parallel flash memory bus. A strap input chooses whether the memory is seen as 16-bit words or as bytes. One 16-bit data bus serves both widths. In byte mode, pin 15 of that bus stops being a data line and becomes the lowest address bit, which picks the upper or lower half of the addressed word. Each data bit has its own output enable, so the surrounding pad logic can tri-state any lane.

Two active-low strobes, chip enable and output enable, decide whether the bus is driven. A separate flag shows that address line 9 is held at a raised voltage. While that flag is set, the read path returns fixed identifier codes instead of array contents. The array is a small bank of registers. Reset fills it with an arithmetic pattern, and it has no write path. Read data follows the inputs in the same cycle, with no wait states.

Top module: `flash_rd_port`

## Requirements
- R1: While `ce_n` is high (standby), `dq_oe` is all zeros, whatever the other inputs are.
- R2: While `ce_n` is low and `oe_n` is high (output disabled), `dq_oe` is all zeros.
- R3: Word read. With `ce_n` and `oe_n` low, `hv_a9` low and `word_mode` high, `dq_oe` is 16'hFFFF and `dq_out` is the word at `addr`, in the same cycle. It holds steady while the inputs do.
- R4: Byte read. With `word_mode` low and the same strobes, `dq_oe` is 16'h00FF. `dq_out[7:0]` is bits 15:8 of the word at `addr` when `dq_in15` is 1, and bits 7:0 when it is 0. `dq_oe[15:8]` is never set in byte mode.
- R5: With both strobes low, `hv_a9` high, `addr[1]`=0 and `addr[0]`=0, `dq_out[7:0]` is 8'hC2.
- R6: With both strobes low, `hv_a9` high, `addr[1]`=0 and `addr[0]`=1, `dq_out[7:0]` is 8'hF6.
- R7: An identifier read in word mode drives all 16 lanes, with `dq_out[15:8]` equal to zero. An identifier read in byte mode enables only lanes 7:0.
- R8: During identifier reads, `addr` bits 2 and up, and `dq_in15`, have no effect. When `addr[1]`=1, the low byte is 8'h00.
- R9: After reset, word i of the array holds (i*INIT_MUL + INIT_ADD) mod 65536. The defaults are INIT_MUL=16'h0B3D and INIT_ADD=16'h5A17.
- R10: Every `dq_out` bit whose `dq_oe` bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register array |
| rst_n | input | 1 | Active-low asynchronous reset; loads the array pattern |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| word_mode | input | 1 | 1 selects 16-bit words, 0 selects bytes |
| addr | input | ADDR_W | Word address; bits 1:0 select the identifier code |
| hv_a9 | input | 1 | Raised-voltage flag on address line 9; selects identifier reads |
| dq_in15 | input | 1 | Input side of pin 15; the byte selector in byte mode |
| dq_out | output | 16 | Data driven onto the bus |
| dq_oe | output | 16 | Per-lane output enable |

## Verification
The assertions assume `rst_n` is held low for at least one clock edge, so the array is loaded before any read is judged. They also assume the strobe, mode and address inputs change only away from the rising edge. The stability check relies on the array never being written after reset. The bench changes every input on the falling edge and waits before sampling. It sweeps every combination of the strobes, width, raised-voltage flag, byte selector and all 32 addresses of the default configuration.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;
  localparam int WORD_W = 16;
  localparam int BYTE_W = 8;
  localparam logic [7:0] MFR_CODE  = 8'hC2;
  localparam logic [7:0] DEV_CODE  = 8'hF6;
  localparam logic [7:0] NULL_CODE = 8'h00;

  typedef enum logic [1:0] {
    RD_STANDBY = 2'd0,
    RD_HIZ     = 2'd1,
    RD_ARRAY   = 2'd2,
    RD_IDENT   = 2'd3
  } rd_mode_e;

  function automatic logic [WORD_W-1:0] init_word(input int unsigned idx,
                                                  input logic [WORD_W-1:0] mul,
                                                  input logic [WORD_W-1:0] add);
    logic [31:0] prod;
    prod = idx * {16'd0, mul};
    return prod[WORD_W-1:0] + add;
  endfunction
endpackage

// File: rtl/flash_rd_array.sv
module flash_rd_array
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [WORD_W-1:0] INIT_MUL = 16'h0B3D,
  parameter logic [WORD_W-1:0] INIT_ADD = 16'h5A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int WORDS = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [WORDS];

  // Contents are fixed at reset; there is no write path in this model.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) begin
        mem[i] <= init_word(i, INIT_MUL, INIT_ADD);
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_rd_decode.sv
module flash_rd_decode
  import flash_rd_pkg::*;
(
  input  logic     ce_n,
  input  logic     oe_n,
  input  logic     hv_id,
  output rd_mode_e mode
);
  // Chip enable outranks output enable, which outranks the identifier flag.
  always_comb begin
    if (ce_n)       mode = RD_STANDBY;
    else if (oe_n)  mode = RD_HIZ;
    else if (hv_id) mode = RD_IDENT;
    else            mode = RD_ARRAY;
  end
endmodule

// File: rtl/flash_rd_bus.sv
module flash_rd_bus
  import flash_rd_pkg::*;
(
  input  rd_mode_e          mode,
  input  logic              word_mode,
  input  logic              hi_sel,
  input  logic [1:0]        id_sel,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] dq_out,
  output logic [WORD_W-1:0] dq_oe
);
  logic [BYTE_W-1:0] id_code;
  logic [BYTE_W-1:0] byte_pick;
  logic [WORD_W-1:0] raw;
  logic              lane_lo_en;
  logic              lane_hi_en;

  always_comb begin
    unique case (id_sel)
      2'b00:   id_code = MFR_CODE;
      2'b01:   id_code = DEV_CODE;
      default: id_code = NULL_CODE;
    endcase
  end

  assign byte_pick = hi_sel ? word[WORD_W-1:BYTE_W] : word[BYTE_W-1:0];

  always_comb begin
    raw = '0;
    if (mode == RD_IDENT)      raw = {{(WORD_W-BYTE_W){1'b0}}, id_code};
    else if (word_mode)        raw = word;
    else                       raw = {{(WORD_W-BYTE_W){1'b0}}, byte_pick};
  end

  assign lane_lo_en = (mode == RD_ARRAY) || (mode == RD_IDENT);
  assign lane_hi_en = lane_lo_en && word_mode;

  // One enable per lane; the upper byte lanes follow the width strap.
  for (genvar b = 0; b < WORD_W; b++) begin : g_lane
    if (b < BYTE_W) begin : g_lo
      assign dq_oe[b] = lane_lo_en;
    end else begin : g_hi
      assign dq_oe[b] = lane_hi_en;
    end
    assign dq_out[b] = raw[b] & dq_oe[b];
  end
endmodule

// File: rtl/flash_rd_port.sv
module flash_rd_port
  import flash_rd_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter logic [15:0] INIT_MUL = 16'h0B3D,
  parameter logic [15:0] INIT_ADD = 16'h5A17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              word_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hv_a9,
  input  logic              dq_in15,
  output logic [15:0]       dq_out,
  output logic [15:0]       dq_oe
);
  rd_mode_e          mode;
  logic [WORD_W-1:0] word;

  flash_rd_array #(
    .ADDR_W  (ADDR_W),
    .INIT_MUL(INIT_MUL),
    .INIT_ADD(INIT_ADD)
  ) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(addr),
    .rd_data(word)
  );

  flash_rd_decode u_decode (
    .ce_n (ce_n),
    .oe_n (oe_n),
    .hv_id(hv_a9),
    .mode (mode)
  );

  flash_rd_bus u_bus (
    .mode     (mode),
    .word_mode(word_mode),
    .hi_sel   (dq_in15),
    .id_sel   (addr[1:0]),
    .word     (word),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe)
  );
endmodule

// File: rtl/flash_rd_port_chk.sv
module flash_rd_port_chk #(
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              word_mode,
  input logic [ADDR_W-1:0] addr,
  input logic              hv_a9,
  input logic [15:0]       dq_out,
  input logic [15:0]       dq_oe
);
  logic active;
  assign active = !ce_n && !oe_n;

  p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> dq_oe == 16'h0000);

  p_out_disable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && oe_n) |-> dq_oe == 16'h0000);

  p_word_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && word_mode && !hv_a9) |-> dq_oe == 16'hFFFF);

  p_word_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && word_mode && !hv_a9 && $stable(addr) && $past(active && word_mode && !hv_a9))
      |-> $stable(dq_out));

  p_byte_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !word_mode) |-> dq_oe == 16'h00FF);

  p_mfr_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hv_a9 && addr[1:0] == 2'b00) |-> dq_out[7:0] == 8'hC2);

  p_dev_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hv_a9 && addr[1:0] == 2'b01) |-> dq_out[7:0] == 8'hF6);

  p_id_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hv_a9 && word_mode) |-> (dq_oe == 16'hFFFF && dq_out[15:8] == 8'h00));

  p_id_null_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && hv_a9 && addr[1]) |-> dq_out[7:0] == 8'h00);

  p_quiet_lanes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_out & ~dq_oe) == 16'h0000);
endmodule

bind flash_rd_port flash_rd_port_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/flash_rd_port_test.sv
module flash_rd_port_test;
  localparam int ADDR_W = 5;
  localparam int WORDS  = 1 << ADDR_W;
  localparam logic [15:0] MUL = 16'h0B3D;
  localparam logic [15:0] ADD = 16'h5A17;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1;
  logic              oe_n = 1'b1;
  logic              word_mode = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              hv_a9 = 1'b0;
  logic              dq_in15 = 1'b0;
  logic [15:0]       dq_out;
  logic [15:0]       dq_oe;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  flash_rd_port #(.ADDR_W(ADDR_W), .INIT_MUL(MUL), .INIT_ADD(ADD)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .word_mode(word_mode),
    .addr(addr), .hv_a9(hv_a9), .dq_in15(dq_in15), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  task automatic check(input string req, input logic [15:0] got_out, input logic [15:0] got_oe,
                       input logic [15:0] exp_out, input logic [15:0] exp_oe);
    checks++;
    if (got_out !== exp_out || got_oe !== exp_oe) begin
      failures++;
      $display("FAIL %s: out=%h oe=%h expected out=%h oe=%h (ce_n=%b oe_n=%b wm=%b hv=%b s15=%b a=%0d)",
               req, got_out, got_oe, exp_out, exp_oe, ce_n, oe_n, word_mode, hv_a9, dq_in15, addr);
    end
  endtask

  initial begin
    #4_000_000;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] w, eo, ee;
    logic [7:0]  code;
    string       req;
    repeat (3) @(negedge clk);
    #2;
    check("R1 reset", dq_out, dq_oe, 16'h0000, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      for (int o = 0; o < 2; o++)
        for (int m = 0; m < 2; m++)
          for (int h = 0; h < 2; h++)
            for (int s = 0; s < 2; s++)
              for (int a = 0; a < WORDS; a++) begin
                @(negedge clk);
                ce_n = c[0]; oe_n = o[0]; word_mode = m[0];
                hv_a9 = h[0]; dq_in15 = s[0]; addr = a[ADDR_W-1:0];
                #5;
                w = 16'(a * MUL) + ADD;
                code = a[1] ? 8'h00 : (a[0] ? 8'hF6 : 8'hC2);
                if (c == 1) begin
                  req = "R1 R10"; eo = 16'h0000; ee = 16'h0000;
                end else if (o == 1) begin
                  req = "R2 R10"; eo = 16'h0000; ee = 16'h0000;
                end else if (h == 1) begin
                  if (a[1]) req = "R8 R7";
                  else if (a >= 4) req = a[0] ? "R6 R8" : "R5 R8";
                  else req = a[0] ? "R6 R7" : "R5 R7";
                  eo = {8'h00, code};
                  ee = (m == 1) ? 16'hFFFF : 16'h00FF;
                end else if (m == 1) begin
                  req = "R3 R9"; eo = w; ee = 16'hFFFF;
                end else begin
                  req = "R4 R9 R10";
                  eo = {8'h00, (s == 1) ? w[15:8] : w[7:0]};
                  ee = 16'h00FF;
                end
                check(req, dq_out, dq_oe, eo, ee);
              end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule